// File: doc/BRIEF.md
# Prescaled Sequencing Timer Bank

This block gives a power-sequencing state machine four timeout timers that share one slow timebase. A free-running prescaler divides the fast system clock by a fixed ratio (32 by default) and issues a one-cycle tick. Every timer counts these ticks. The tick can also be driven out to the sequencing logic as a slow clock-enable, under control of a static switch input.

Each timer has a start level input, a 7-bit interval code and a done flag. A rising edge on start clears the timer and begins a count. The done flag rises once the number of ticks selected by the code has elapsed, and it stays high as long as start is held high. Dropping start aborts the timer at once. The code maps to a tick count through a floating-point style decode: three mantissa bits and four exponent bits. This spreads the intervals roughly geometrically, from one tick up to 61440 ticks. With the default ratio that range runs from 32 µs to about 1.97 s.

Top module: `seq_timer_bank`

## Requirements
- R1: While rst_ni is low, all done_o bits and tick_o are 0. After reset is released, no timer is running.
- R2: The internal tick is high for exactly one clock in every PRESCALE clocks and is never high in two consecutive clocks.
- R3: tick_o shows the internal tick only while tick_out_en_i is 1 and is held at 0 otherwise. The timers keep counting in both cases.
- R4: The interval in ticks for code c is ((8 + c[2:0]) << c[6:3]) >> 3. Code 0 gives 1 tick and code 127 gives 61440 ticks.
- R5: A rising edge of start_i[i] clears timer i's count and done flag in that cycle. A tick present in that same cycle is not counted.
- R6: After the start edge, done_o[i] rises in the clock after the tick that brings the count to the interval of R4. It then stays 1 while start_i[i] stays 1.
- R7: start_i[i] low clears done_o[i] and the count by the next clock, whatever the timer's state. A later rising edge restarts the count from zero.
- R8: Each of the four timers runs on its own code and start. Activity on one timer does not change the done timing of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_out_en_i | input | 1 | Switch enabling the export of the prescaled tick |
| start_i | input | N_TIMERS | Per-timer start level; the rising edge starts the timer, low aborts it |
| code_i | input | N_TIMERS*7 | Per-timer interval code, timer i in bits [7i+6:7i] |
| tick_o | output | 1 | Exported one-cycle timebase tick (clock-enable) |
| done_o | output | N_TIMERS | Per-timer elapsed flag |

## Verification
The bench uses a divide-by-2 timebase. It sweeps every code whose exponent field is at most 8, plus the longest code. For each code it checks done_o against the tick count on every cycle, so an off-by-one in the decode or in the comparison shows up as done rising one tick early or late. A tick that coincides with the start edge is a key case: a design that counted it would finish one tick early on short codes. The bench also aborts a timer mid-count and then restarts it. A design that kept the stale count would finish short, and one that left done set after start dropped would report a false completion. Finally, all four timers run at once with different codes to expose shared or crossed counter state, and the bench turns the export switch off to confirm that the timers keep running while tick_o stays silent.

// File: rtl/seq_timer_pkg.sv
package seq_timer_pkg;
  localparam int MANT_W = 3;
  localparam int EXP_W  = 4;
  localparam int CODE_W = MANT_W + EXP_W;
  localparam int TICK_W = 16;
  localparam int FULL_W = TICK_W + MANT_W;

  // ((1.mant) << exp) >> MANT_W : roughly geometric interval spacing
  function automatic logic [TICK_W-1:0] interval_ticks(input logic [CODE_W-1:0] code);
    logic [FULL_W-1:0] full;
    full = FULL_W'({1'b1, code[MANT_W-1:0]}) << code[CODE_W-1:MANT_W];
    return full[FULL_W-1:MANT_W];
  endfunction
endpackage

// File: rtl/seq_prescaler.sv
module seq_prescaler #(
  parameter int PRESCALE = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int PS_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PS_W-1:0] LAST = PS_W'(PRESCALE - 1);

  logic [PS_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = rst_ni && (cnt_q == LAST);
endmodule

// File: rtl/seq_interval_lut.sv
module seq_interval_lut
  import seq_timer_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic [TICK_W-1:0] ticks_o
);
  always_comb ticks_o = interval_ticks(code_i);
endmodule

// File: rtl/seq_timer_unit.sv
module seq_timer_unit
  import seq_timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              done_o
);
  logic [TICK_W-1:0] target;
  logic [TICK_W-1:0] cnt_q;
  logic [TICK_W:0]   cnt_nxt;
  logic              start_q;
  logic              done_q;
  logic              start_rise;

  seq_interval_lut u_lut (
    .code_i  (code_i),
    .ticks_o (target)
  );

  assign start_rise = start_i && !start_q;
  assign cnt_nxt    = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_q <= 1'b0;
    else         start_q <= start_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!start_i || start_rise) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (tick_i && !done_q) begin
      cnt_q <= cnt_nxt[TICK_W-1:0];
      // >= keeps a code change mid-run from overrunning
      if (cnt_nxt >= {1'b0, target}) done_q <= 1'b1;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/seq_timer_bank.sv
module seq_timer_bank
  import seq_timer_pkg::*;
#(
  parameter int N_TIMERS = 4,
  parameter int PRESCALE = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       tick_out_en_i,
  input  logic [N_TIMERS-1:0]        start_i,
  input  logic [N_TIMERS*CODE_W-1:0] code_i,
  output logic                       tick_o,
  output logic [N_TIMERS-1:0]        done_o
);
  logic tick;

  seq_prescaler #(.PRESCALE(PRESCALE)) u_prescaler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  for (genvar i = 0; i < N_TIMERS; i++) begin : g_timer
    seq_timer_unit u_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick),
      .start_i (start_i[i]),
      .code_i  (code_i[i*CODE_W +: CODE_W]),
      .done_o  (done_o[i])
    );
  end

  assign tick_o = tick && tick_out_en_i;
endmodule

// File: rtl/seq_timer_bank_chk.sv
module seq_timer_bank_chk
  import seq_timer_pkg::*;
#(
  parameter int N_TIMERS = 4,
  parameter int PRESCALE = 32
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       tick_out_en_i,
  input logic [N_TIMERS-1:0]        start_i,
  input logic [N_TIMERS*CODE_W-1:0] code_i,
  input logic                       tick_o,
  input logic [N_TIMERS-1:0]        done_o
);
  if (PRESCALE > 1) begin : g_tick
    AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o); // R2
  end

  for (genvar i = 0; i < N_TIMERS; i++) begin : g_unit
    AST_ABORT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !start_i[i] |=> !done_o[i]); // R7
    AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(start_i[i]) |=> !done_o[i]); // R5
    AST_DONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o[i] && start_i[i]) |=> done_o[i]); // R6
    AST_DONE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(done_o[i]) && $past(tick_out_en_i)) |-> $past(tick_o)); // R6
    AST_DONE_NEEDS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(done_o[i]) |-> $past(start_i[i])); // R5
  end
endmodule

bind seq_timer_bank seq_timer_bank_chk #(
  .N_TIMERS (N_TIMERS),
  .PRESCALE (PRESCALE)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tick_out_en_i (tick_out_en_i),
  .start_i       (start_i),
  .code_i        (code_i),
  .tick_o        (tick_o),
  .done_o        (done_o)
);

// File: tb/seq_timer_bank_bench.sv
module seq_timer_bank_bench;
  localparam int N  = 4;
  localparam int PS = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1;
  logic [3:0] start_r = '0;
  logic [6:0] code_r [4];
  logic [27:0] code_bus;
  logic       tick_o;
  logic [3:0] done_o;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  assign code_bus = {code_r[3], code_r[2], code_r[1], code_r[0]};

  seq_timer_bank #(.N_TIMERS(N), .PRESCALE(PS)) u_seq_timer_bank (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .tick_out_en_i (en),
    .start_i       (start_r),
    .code_i        (code_bus),
    .tick_o        (tick_o),
    .done_o        (done_o)
  );

  function automatic int exp_ticks(input int c);
    return ((8 + (c % 8)) * (1 << (c / 8))) / 8;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // start timers in mask; verify done on every cycle against ticks seen
  task automatic run_set(input logic [3:0] mask, input string req, input int extra);
    int tgt[4];
    int seen = 0;
    int maxt = 0;
    int bad = 0;
    int bact = 0;
    int bexp = 0;
    for (int i = 0; i < 4; i++) begin
      tgt[i] = exp_ticks(int'(code_r[i]));
      if (mask[i] && tgt[i] > maxt) maxt = tgt[i];
    end
    @(negedge clk);
    start_r = start_r | mask;
    while (seen < maxt + extra) begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
        if (mask[i] && (done_o[i] !== (seen >= tgt[i]))) begin
          if (bad == 0) begin bact = int'(done_o[i]); bexp = int'(seen >= tgt[i]); end
          bad++;
        end
      end
      if (tick_o) seen++;
    end
    check(bad == 0, req, "done vs elapsed ticks", bact, bexp);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int hi;
    int pairs;
    logic prev;
    for (int i = 0; i < 4; i++) code_r[i] = '0;
    repeat (3) @(negedge clk);
    check(done_o == 4'b0, "R1", "done in reset", done_o, 0);
    check(tick_o == 1'b0, "R1", "tick in reset", tick_o, 0);
    rst_n = 1'b1;

    // R2: tick period
    hi = 0; pairs = 0; prev = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (tick_o) hi++;
      if (tick_o && prev) pairs++;
      prev = tick_o;
    end
    check(hi == 40 / PS, "R2", "ticks in 40 clocks", hi, 40 / PS);
    check(pairs == 0, "R2", "back-to-back ticks", pairs, 0);
    check(done_o == 4'b0, "R1", "done idle after reset", done_o, 0);

    // R4/R5/R6: sweep codes with exponent <= 8 across timers
    for (int c = 0; c < 72; c++) begin
      code_r[c % 4] = 7'(c);
      run_set(4'(1 << (c % 4)), "R4", 3);
      @(negedge clk);
      check(done_o[c % 4] == 1'b1, "R6", "done held while start high", done_o[c % 4], 1);
      start_r = '0;
      @(negedge clk);
      check(done_o[c % 4] == 1'b0, "R7", "done cleared by start low", done_o[c % 4], 0);
    end

    // R3: export disabled, timers still run
    en = 1'b0;
    code_r[1] = 7'd3;   // 1 tick
    @(negedge clk);
    start_r[1] = 1'b1;
    hi = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (tick_o) hi++;
    end
    check(hi == 0, "R3", "tick_o while disabled", hi, 0);
    check(done_o[1] == 1'b1, "R3", "timer ran with export off", done_o[1], 1);
    start_r = '0;
    en = 1'b1;
    @(negedge clk);

    // R7: abort mid-run then restart from zero
    code_r[2] = 7'd20;  // 6 ticks
    @(negedge clk);
    start_r[2] = 1'b1;
    repeat (6) @(negedge clk);
    check(done_o[2] == 1'b0, "R7", "not done mid-run", done_o[2], 0);
    start_r[2] = 1'b0;
    hi = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (done_o[2]) hi++;
    end
    check(hi == 0, "R7", "done while aborted", hi, 0);
    run_set(4'b0100, "R7", 2);

    // R5: restart after completion
    start_r[2] = 1'b0;
    @(negedge clk);
    run_set(4'b0100, "R5", 2);
    start_r = '0;
    @(negedge clk);

    // R8: four timers at once
    code_r[0] = 7'd8;  code_r[1] = 7'd16;
    code_r[2] = 7'd24; code_r[3] = 7'd32;
    run_set(4'b1111, "R8", 3);
    start_r = '0;
    @(negedge clk);
    code_r[0] = 7'd33; code_r[1] = 7'd1;
    code_r[2] = 7'd41; code_r[3] = 7'd12;
    run_set(4'b1111, "R8", 3);
    start_r = '0;
    @(negedge clk);

    // R4: longest code
    code_r[3] = 7'd127;
    check(exp_ticks(127) == 61440, "R4", "longest code ticks", exp_ticks(127), 61440);
    run_set(4'b1000, "R4", 2);
    start_r = '0;
    @(negedge clk);
    check(done_o == 4'b0, "R7", "all clear after stop", done_o, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule